// File: doc/BRIEF.md
# Pipelined Length-8 Polar Encoder

This block turns a 4-bit information word into an 8-bit polar codeword. It places the four information bits into a fixed set of positions of an 8-bit vector and zeroes the other four, the frozen positions. It then multiplies that vector over GF(2) by the third Kronecker power of the 2x2 kernel [[1,0],[1,1]]. A three-level XOR butterfly network performs the multiplication.

The datapath has three register stages:
- a 4-bit register that captures the information word;
- an 8-bit register that holds the vector after frozen-bit insertion;
- an 8-bit register between the butterfly network and the outputs.

A valid flag travels with the data through each stage. The block accepts one word on every clock and has no backpressure. When the stream has gaps, the output codeword is held at zero.

Top module: `polar_enc8`

## Requirements
- R1: A synchronous active-high reset clears all stages. On the first falling edge after a reset edge, `out_valid` is 0 and `out_code` is 0.
- R2: A word presented with `in_valid`=1 before rising edge t appears with `out_valid`=1 after rising edge t+2, a latency of three register stages. `out_valid` follows `in_valid` with exactly that delay.
- R3: Vector positions 0, 1, 2 and 4 are frozen to zero. As a consequence, every valid codeword c satisfies four parity checks, each equal to 0:
  - c0^c1^...^c7
  - c1^c3^c5^c7
  - c2^c3^c6^c7
  - c4^c5^c6^c7
- R4: The information bits map to the vector as u3=q[2], u5=q[0], u6=q[3] and u7=q[1]. This is the order q2, q0, q3, q1 over the rising information indices. As examples, q=0001 gives 0x33, q=0010 gives 0xFF, q=0100 gives 0x0F and q=1000 gives 0x55.
- R5: The codeword is c_j = XOR of u_i over all i whose bits include every bit of j. This is the product u*G8, with bit j of `out_code` holding c_j. All 16 information words encode this way.
- R6: When `out_valid` is 0, `out_code` is 0.
- R7: Words arriving on consecutive clocks each produce their own codeword on consecutive clocks, one per cycle.
- R8: Idle cycles placed between valid words do not change the codewords of the surrounding words.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Information word strobe |
| in_info | input | 4 | Information bits q[3:0] |
| out_valid | output | 1 | Codeword strobe |
| out_code | output | 8 | Codeword, bit j is c_j |

## Verification
A fault in an internal stage register reaches the ports within three clocks. A stuck or skipped valid flag moves `out_valid` away from the delayed copy of `in_valid`. A corrupted data bit shows up in the codeword of the very word it touched. A wrong bit mapping or a wrong butterfly span changes specific codewords, and the one-hot information words isolate which bit is wrong. A corrupted frozen position breaks one of the four parity checks on every affected word.

// File: rtl/polar_enc8.sv
module polar_enc8 #(
  parameter int KBITS = 4,
  parameter int NBITS = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             in_valid,
  input  logic [KBITS-1:0] in_info,
  output logic             out_valid,
  output logic [NBITS-1:0] out_code
);
  localparam int LEVELS = $clog2(NBITS);

  logic             v1, v2, v3;
  logic [KBITS-1:0] info_q;
  logic [NBITS-1:0] vec_q, code_q;
  logic [NBITS-1:0] vec_d;
  logic [NBITS-1:0] lvl [LEVELS+1];

  always_ff @(posedge clk) begin
    if (rst) begin
      v1     <= 1'b0;
      info_q <= '0;
    end else begin
      v1     <= in_valid;
      info_q <= in_valid ? in_info : '0;
    end
  end

  assign vec_d = {info_q[1], info_q[3], info_q[0], 1'b0, info_q[2], 3'b000};

  always_ff @(posedge clk) begin
    if (rst) begin
      v2    <= 1'b0;
      vec_q <= '0;
    end else begin
      v2    <= v1;
      vec_q <= vec_d;
    end
  end

  assign lvl[0] = vec_q;
  for (genvar l = 0; l < LEVELS; l++) begin : g_lvl
    localparam int SPAN = NBITS >> (l + 1);
    for (genvar i = 0; i < NBITS; i++) begin : g_bit
      if ((i & SPAN) == 0) begin : g_xor
        assign lvl[l+1][i] = lvl[l][i] ^ lvl[l][i+SPAN];
      end else begin : g_pass
        assign lvl[l+1][i] = lvl[l][i];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      v3     <= 1'b0;
      code_q <= '0;
    end else begin
      v3     <= v2;
      code_q <= lvl[LEVELS];
    end
  end

  assign out_valid = v3;
  assign out_code  = code_q;

  a_r1_reset_clear: assert property (@(posedge clk)
    rst |=> (!out_valid && out_code == '0));

  a_r2_valid_chain: assert property (@(posedge clk) disable iff (rst)
    v2 |=> out_valid);

  a_r6_idle_zero: assert property (@(posedge clk) disable iff (rst)
    !out_valid |-> out_code == '0);

  a_r3_frozen_parity: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> ((^out_code) == 1'b0
                   && (out_code[1]^out_code[3]^out_code[5]^out_code[7]) == 1'b0
                   && (out_code[2]^out_code[3]^out_code[6]^out_code[7]) == 1'b0
                   && (out_code[4]^out_code[5]^out_code[6]^out_code[7]) == 1'b0));

  a_r4_last_bit: assert property (@(posedge clk) disable iff (rst)
    $rose(out_valid) |-> out_code[7] == $past(vec_q[7]));
endmodule

// File: tb/polar_enc8_tb.sv
module polar_enc8_tb_top;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       in_valid = 1'b0;
  logic [3:0] in_info = '0;
  logic       out_valid;
  logic [7:0] out_code;

  int checks = 0;
  int fails  = 0;

  bit         q_v[$];
  logic [7:0] q_c[$];
  string      q_t[$];

  always #10 clk = ~clk;

  polar_enc8 dut_i (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_info(in_info),
    .out_valid(out_valid), .out_code(out_code)
  );

  function automatic logic [7:0] ref_code(input logic [3:0] q);
    logic [7:0] u;
    logic [7:0] x;
    u = '0;
    u[3] = q[2]; u[5] = q[0]; u[6] = q[3]; u[7] = q[1];
    x = '0;
    for (int j = 0; j < 8; j++)
      for (int i = 0; i < 8; i++)
        if ((j & ~i & 7) == 0) x[j] = x[j] ^ u[i];
    return x;
  endfunction

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic prefill();
    q_v.delete(); q_c.delete(); q_t.delete();
    repeat (3) begin q_v.push_back(1'b0); q_c.push_back(8'h00); q_t.push_back("R6"); end
  endtask

  task automatic step(input bit v, input logic [3:0] q, input string tag);
    bit         ev;
    logic [7:0] ec;
    string      et;
    @(negedge clk);
    ev = q_v.pop_front(); ec = q_c.pop_front(); et = q_t.pop_front();
    check({"R2 ", et}, {7'd0, out_valid}, {7'd0, ev});
    check(ev ? et : "R6", out_code, ec);
    in_valid = v;
    in_info  = q;
    q_v.push_back(v);
    q_c.push_back(v ? ref_code(q) : 8'h00);
    q_t.push_back(tag);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1; in_valid = 1'b0; in_info = '0;
    @(negedge clk);
    check("R1 valid", {7'd0, out_valid}, 8'h00);
    check("R1 code", out_code, 8'h00);
    rst = 1'b0;
    prefill();
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    do_reset();
    step(1'b1, 4'b0001, "R4");
    step(1'b1, 4'b0010, "R4");
    step(1'b1, 4'b0100, "R4");
    step(1'b1, 4'b1000, "R4");
    step(1'b0, 4'b0000, "R6");
    for (int w = 0; w < 16; w++) step(1'b1, w[3:0], "R5 R7");
    for (int w = 15; w >= 0; w--) begin
      step(1'b1, w[3:0], "R8");
      for (int g = 0; g < (w % 3); g++) step(1'b0, 4'hF, "R8");
    end
    for (int n = 0; n < 40; n++) step(1'b1, n[3:0] ^ 4'h9, "R3 R7");
    step(1'b1, 4'hA, "R1");
    step(1'b1, 4'h5, "R1");
    do_reset();
    step(1'b1, 4'h3, "R2");
    repeat (4) step(1'b0, 4'h0, "R6");
    @(negedge clk);
    check("R4 0001", ref_code(4'b0001), 8'h33);
    check("R4 1000", ref_code(4'b1000), 8'h55);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule